// File: doc/BRIEF.md
# Bus Address Map Register File

This block keeps a table of relocation registers that turn an 18-bit peripheral bus address into a 22-bit physical memory address for DMA transfers. The bus address space is cut into 32 pages of 8 KiB. Bits 17:13 of a bus address pick a page and bits 12:0 are the offset within it. Each page has a 22-bit base stored in the table. A DMA engine presents a bus address on the translation port and gets back a physical address and a flag. The flag says whether that address lies inside the installed memory. The translation is combinational.

The CPU reaches each table entry through two 16-bit registers. The even register of the pair carries the low 16 bits, and its bit 0 is always zero. The odd register carries the upper 6 bits. Registers can be written a byte or a word at a time and are read a word at a time. The top bus page is not relocated: it always points at the I/O page at the top of physical space. A global enable turns translation off, and the bus address then passes straight through. A presence input models a system built without the map. In that case every register access is refused with a non-existent-memory indication.

Top module: `ubmap_top`

## Requirements
- R1: After a synchronous active-low reset every table entry is zero, so every map register reads 0.
- R2: A word write to the even register of a pair (`reg_addr[1]`=0) sets bits 15:0 of the entry. Bit 0 is forced to zero, and that register then reads back the written value with bit 0 cleared.
- R3: A word write to the odd register (`reg_addr[1]`=1) sets entry bits 21:16 from data bits 5:0. A read of the odd register returns the entry's upper 6 bits in bits 5:0, with bits 15:6 zero.
- R4: A byte write (`reg_byte`=1) puts `reg_wdata[7:0]` into the byte lane given by `reg_addr[1:0]` (lane 0 = bits 7:0 up to lane 3 = bits 31:24) of a 32-bit view of the entry. The result is then cut to 22 bits with bit 0 cleared, so lane 3 is discarded and lane 2 keeps only 6 bits. The other lanes are unchanged.
- R5: The entry index is `reg_addr[6:2]`. A write changes only the addressed entry.
- R6: With `map_present`=0 any access with `reg_sel`=1 raises `reg_nxm` in the same cycle. A write in that state leaves the table unchanged, and `reg_rdata` reads 0. With `map_present`=1 `reg_nxm` stays low.
- R7: With `map_enable`=1 and a page below 31, `phys_addr` equals the page's entry plus the 13-bit offset, truncated to 22 bits (the carry out is dropped).
- R8: With `map_enable`=1 and page 31, `phys_addr` is the I/O page base 0x3FE000 plus the offset, whatever entry 31 holds.
- R9: With `map_enable`=0, `phys_addr` is `bus_addr` zero-extended to 22 bits.
- R10: `phys_valid` is 1 exactly when `phys_addr` is below the configured memory size (default 2 MiB, 0x200000).
- R11: Register reads and translation are combinational. A write takes effect at the clock edge on which `reg_sel` and `reg_wr` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_present | input | 1 | 1 when the map hardware exists in this system |
| map_enable | input | 1 | 1 to relocate bus addresses through the table |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_byte | input | 1 | 1 for a byte write, 0 for a word write |
| reg_addr | input | 7 | Register byte address within the map window |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| reg_nxm | output | 1 | Non-existent-memory indication for a refused access |
| bus_addr | input | 18 | Bus address to translate |
| phys_addr | output | 22 | Translated physical address |
| phys_valid | output | 1 | Physical address lies within installed memory |

## Verification
The assertions check these rules on every cycle:
- the low-word write result and the cleared bit 0 (R2);
- the zero upper bits of an odd-register read (R3);
- that writes are refused while the map is absent (R6);
- the fixed I/O page for the top page (R8);
- pass-through when translation is off (R9).

Some behaviour only the directed scenarios can show:
- byte-lane merging, including lane 3 being discarded (R4);
- isolation between entries (R5);
- the wrap of an entry plus offset past 22 bits (R7);
- the exact edge of the memory-size flag (R10);
- the cleared state after reset (R1).

// File: rtl/ubmap_pkg.sv
// Package: ubmap_pkg
// Shared sizes and constants for the bus address map.
// Assumes a 16-bit register data path and byte-addressed registers.
package ubmap_pkg;
    localparam int REG_DW     = 16;   // register data width
    localparam int STORE_W    = 32;   // width of the merge view of an entry
    localparam int LANE_W     = 8;    // one byte lane
    localparam int REG_SUB_W  = 2;    // byte address bits within an entry
endpackage

// File: rtl/ubmap_entry_file.sv
// Module: ubmap_entry_file
// Holds the page relocation entries. Merges byte or word writes into a
// 32-bit view of the addressed entry, then masks the result to PHYS_AW bits
// with bit 0 cleared.
// Assumes wr_en is already qualified by presence and the write strobe.
module ubmap_entry_file
    import ubmap_pkg::*;
#(
    parameter int NUM_PAGES = 32,
    parameter int PHYS_AW   = 22,
    localparam int PN_W     = $clog2(NUM_PAGES),
    localparam int REG_AW   = PN_W + REG_SUB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_byte,
    input  logic [REG_AW-1:0]  wr_addr,
    input  logic [REG_DW-1:0]  wr_data,
    output logic [PHYS_AW-1:0] entries [NUM_PAGES]
);
    localparam logic [STORE_W-1:0] KEEP_MASK =
        STORE_W'(((64'd1 << PHYS_AW) - 64'd1) & ~64'd1);

    logic [PN_W-1:0]    wr_pn;
    logic [1:0]         wr_lane;
    logic [STORE_W-1:0] old_view;
    logic [STORE_W-1:0] merged;
    logic [STORE_W-1:0] masked;

    assign wr_pn   = wr_addr[REG_AW-1:REG_SUB_W];
    assign wr_lane = wr_addr[1:0];

    // Merge the write data into the selected lane or half of the old entry.
    always_comb begin
        old_view = STORE_W'(entries[wr_pn]);
        merged   = old_view;
        if (wr_byte) begin
            merged[{3'(wr_lane), 3'd0} +: LANE_W] = wr_data[LANE_W-1:0];
        end else if (wr_lane[1]) begin
            merged[STORE_W-1:REG_DW] = wr_data;
        end else begin
            merged[REG_DW-1:0] = wr_data;
        end
        masked = merged & KEEP_MASK;
    end

    // Clear the table on reset; store the masked entry on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                entries[i] <= '0;
            end
        end else if (wr_en) begin
            entries[wr_pn] <= masked[PHYS_AW-1:0];
        end
    end

    // R2: a low word write lands with bit 0 cleared.
    a_r2_low_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte && !wr_lane[1]) |=>
        (entries[$past(wr_pn)][15:0] == ($past(wr_data) & 16'hFFFE)));

    // R2: no write ever leaves bit 0 set.
    a_r2_bit0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (entries[$past(wr_pn)][0] == 1'b0));
endmodule

// File: rtl/ubmap_reg_read.sv
// Module: ubmap_reg_read
// Combinational read mux for the register window. The even register gives
// the low 16 bits with bit 0 cleared. The odd register gives the upper bits,
// zero-extended. Reads 0 when the map is absent.
module ubmap_reg_read
    import ubmap_pkg::*;
#(
    parameter int NUM_PAGES = 32,
    parameter int PHYS_AW   = 22,
    localparam int PN_W     = $clog2(NUM_PAGES),
    localparam int REG_AW   = PN_W + REG_SUB_W,
    localparam int HI_W     = PHYS_AW - REG_DW
) (
    input  logic [PHYS_AW-1:0] entries [NUM_PAGES],
    input  logic               present,
    input  logic [REG_AW-1:0]  rd_addr,
    output logic [REG_DW-1:0]  rd_data
);
    logic [PHYS_AW-1:0] sel_entry;

    assign sel_entry = entries[rd_addr[REG_AW-1:REG_SUB_W]];

    // Pick the half addressed by rd_addr[1], or 0 when absent.
    always_comb begin
        if (!present) begin
            rd_data = '0;
        end else if (rd_addr[1]) begin
            rd_data = {{(REG_DW-HI_W){1'b0}}, sel_entry[PHYS_AW-1:REG_DW]};
        end else begin
            rd_data = {sel_entry[REG_DW-1:1], 1'b0};
        end
    end
endmodule

// File: rtl/ubmap_xlate.sv
// Module: ubmap_xlate
// Combinational bus to physical address translation. The top page goes to
// the fixed I/O page base. The valid flag compares against the memory size.
// Assumes BUS_AW - OFF_W equals the page-number width.
module ubmap_xlate #(
    parameter int NUM_PAGES = 32,
    parameter int PHYS_AW   = 22,
    parameter int BUS_AW    = 18,
    parameter int OFF_W     = 13,
    parameter logic [PHYS_AW-1:0] IO_BASE = 22'h3FE000,
    parameter int MEM_BYTES = 2097152,
    localparam int PN_W     = $clog2(NUM_PAGES)
) (
    input  logic [PHYS_AW-1:0] entries [NUM_PAGES],
    input  logic               enable,
    input  logic [BUS_AW-1:0]  bus_addr,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               phys_valid
);
    localparam logic [PHYS_AW:0] MEM_LIM = (PHYS_AW+1)'(MEM_BYTES);

    logic [PN_W-1:0]    pn;
    logic [PHYS_AW-1:0] off_ext;
    logic [PHYS_AW-1:0] base;

    assign pn      = bus_addr[BUS_AW-1:OFF_W];
    assign off_ext = PHYS_AW'(bus_addr[OFF_W-1:0]);

    // Choose the page base: the fixed I/O page for the top page, else the table.
    always_comb begin
        if (pn == PN_W'(NUM_PAGES - 1)) begin
            base = IO_BASE;
        end else begin
            base = entries[pn];
        end
    end

    // Relocate when enabled, else pass the bus address through.
    always_comb begin
        if (enable) begin
            phys_addr = base + off_ext;
        end else begin
            phys_addr = PHYS_AW'(bus_addr);
        end
    end

    // Flag addresses that fall inside installed memory.
    assign phys_valid = ({1'b0, phys_addr} < MEM_LIM);
endmodule

// File: rtl/ubmap_top.sv
// Module: ubmap_top
// Bus address map: register window for the CPU plus a combinational
// translation port for DMA. Refuses register access when the map is absent.
// Assumes one register access per cycle with reg_sel as its strobe.
module ubmap_top
    import ubmap_pkg::*;
#(
    parameter int NUM_PAGES = 32,
    parameter int PHYS_AW   = 22,
    parameter int BUS_AW    = 18,
    parameter int OFF_W     = 13,
    parameter logic [PHYS_AW-1:0] IO_BASE = 22'h3FE000,
    parameter int MEM_BYTES = 2097152,
    localparam int PN_W     = $clog2(NUM_PAGES),
    localparam int REG_AW   = PN_W + REG_SUB_W,
    localparam int HI_W     = PHYS_AW - REG_DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_present,
    input  logic               map_enable,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic               reg_byte,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [REG_DW-1:0]  reg_wdata,
    output logic [REG_DW-1:0]  reg_rdata,
    output logic               reg_nxm,
    input  logic [BUS_AW-1:0]  bus_addr,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               phys_valid
);
    logic [PHYS_AW-1:0] entries [NUM_PAGES];
    logic               wr_en;
    logic [PHYS_AW-1:0] addr_entry;

    // Qualify writes by presence; refused accesses flag non-existent memory.
    assign wr_en      = reg_sel && reg_wr && map_present;
    assign reg_nxm    = reg_sel && !map_present;
    assign addr_entry = entries[reg_addr[REG_AW-1:REG_SUB_W]];

    ubmap_entry_file #(.NUM_PAGES(NUM_PAGES), .PHYS_AW(PHYS_AW)) i_entries (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_byte (reg_byte),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .entries (entries)
    );

    ubmap_reg_read #(.NUM_PAGES(NUM_PAGES), .PHYS_AW(PHYS_AW)) i_read (
        .entries (entries),
        .present (map_present),
        .rd_addr (reg_addr),
        .rd_data (reg_rdata)
    );

    ubmap_xlate #(
        .NUM_PAGES (NUM_PAGES),
        .PHYS_AW   (PHYS_AW),
        .BUS_AW    (BUS_AW),
        .OFF_W     (OFF_W),
        .IO_BASE   (IO_BASE),
        .MEM_BYTES (MEM_BYTES)
    ) i_xlate (
        .entries    (entries),
        .enable     (map_enable),
        .bus_addr   (bus_addr),
        .phys_addr  (phys_addr),
        .phys_valid (phys_valid)
    );

    // R6: a refused write leaves the addressed entry untouched.
    a_r6_absent_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && !map_present) |=>
        (entries[$past(reg_addr[REG_AW-1:REG_SUB_W])] == $past(addr_entry)));

    // R3: odd register reads carry nothing above the upper field.
    a_r3_high_read: assert property (@(posedge clk) disable iff (!rst_n)
        (map_present && reg_addr[1]) |-> (reg_rdata[REG_DW-1:HI_W] == '0));

    // R8: the top bus page always lands in the I/O page.
    a_r8_io_page: assert property (@(posedge clk) disable iff (!rst_n)
        (map_enable && (bus_addr[BUS_AW-1:OFF_W] == PN_W'(NUM_PAGES - 1))) |->
        (phys_addr[PHYS_AW-1:OFF_W] == IO_BASE[PHYS_AW-1:OFF_W]));

    // R9: with translation off the upper physical bits are zero.
    a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !map_enable |-> ((phys_addr[PHYS_AW-1:BUS_AW] == '0) &&
                         (phys_addr[BUS_AW-1:0] == bus_addr)));
endmodule

// File: tb/test_ubmap_top.sv
// Directed bench for ubmap_top. Inputs change on the falling edge and
// outputs are sampled 1 ns later, well away from the rising edge.
module test_ubmap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_present = 1'b1;
    logic        map_enable = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_byte = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_nxm;
    logic [17:0] bus_addr = '0;
    logic [21:0] phys_addr;
    logic        phys_valid;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ubmap_top i_ubmap_top (
        .clk(clk), .rst_n(rst_n), .map_present(map_present),
        .map_enable(map_enable), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_byte(reg_byte), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_nxm(reg_nxm), .bus_addr(bus_addr),
        .phys_addr(phys_addr), .phys_valid(phys_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d, input bit byte_w);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_byte = byte_w;
        reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; reg_byte = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [6:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1;
        check(req, {16'h0, reg_rdata}, {16'h0, exp});
        reg_sel = 1'b0;
    endtask

    task automatic xl_check(input string req, input logic [17:0] ba,
                            input logic [21:0] exp_pa, input bit exp_v);
        @(negedge clk);
        bus_addr = ba;
        #1;
        check(req, {10'h0, phys_addr}, {10'h0, exp_pa});
        check({req, " valid"}, {31'h0, phys_valid}, {31'h0, exp_v});
    endtask

    // R1: every register reads zero after reset.
    task automatic t_reset;
        int bad = 0;
        for (int a = 0; a < 128; a += 2) begin
            @(negedge clk);
            reg_sel = 1'b1; reg_addr = 7'(a);
            #1;
            if (reg_rdata !== 16'h0) bad++;
        end
        reg_sel = 1'b0;
        check("R1 reset all zero", bad, 0);
        check("R6 nxm low when present", {31'h0, reg_nxm}, 0);
    endtask

    // R2, R3, R11: word writes to both halves of page 0.
    task automatic t_word;
        wr(7'd0, 16'hABCD, 1'b0);
        rd_check("R2 low word bit0 cleared", 7'd0, 16'hABCC);
        wr(7'd2, 16'hFFFF, 1'b0);
        rd_check("R3 high keeps 6 bits", 7'd2, 16'h003F);
        rd_check("R11 low unchanged by high write", 7'd0, 16'hABCC);
    endtask

    // R5: index from address bits 6:2, neighbours untouched.
    task automatic t_index;
        wr(7'd20, 16'h1234, 1'b0);
        wr(7'd22, 16'h0002, 1'b0);
        rd_check("R5 page5 low", 7'd20, 16'h1234);
        rd_check("R5 page5 high", 7'd22, 16'h0002);
        rd_check("R5 page4 untouched", 7'd16, 16'h0000);
        rd_check("R5 page6 untouched", 7'd24, 16'h0000);
    endtask

    // R4: byte lanes on page 7 (addresses 28..31).
    task automatic t_byte;
        wr(7'd28, 16'hFFFF, 1'b0);
        wr(7'd29, 16'h005A, 1'b1);
        rd_check("R4 lane1", 7'd28, 16'h5AFE);
        wr(7'd28, 16'hAA33, 1'b1);
        rd_check("R4 lane0 bit0 cleared", 7'd28, 16'h5A32);
        wr(7'd30, 16'h00C7, 1'b1);
        rd_check("R4 lane2 6 bits", 7'd30, 16'h0007);
        wr(7'd31, 16'h00FF, 1'b1);
        rd_check("R4 lane3 discarded", 7'd30, 16'h0007);
        rd_check("R4 low unchanged", 7'd28, 16'h5A32);
    endtask

    // R6: absent map refuses access and keeps the table.
    task automatic t_absent;
        @(negedge clk);
        map_present = 1'b0;
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 7'd20; reg_wdata = 16'hFFFF;
        #1;
        check("R6 nxm on write", {31'h0, reg_nxm}, 1);
        check("R6 rdata zero", {16'h0, reg_rdata}, 0);
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
        map_present = 1'b1;
        rd_check("R6 write ignored", 7'd20, 16'h1234);
    endtask

    // R7, R8, R10: mapped translation.
    task automatic t_mapped;
        @(negedge clk);
        map_enable = 1'b1;
        xl_check("R7 page5 plus offset", 18'h0A100, 22'h021334, 1'b1);
        wr(7'd0, 16'hFFFE, 1'b0);
        xl_check("R7 wrap at 22 bits", 18'h00010, 22'h00000E, 1'b1);
        wr(7'd124, 16'h4000, 1'b0);
        xl_check("R8 top page to io", 18'h3E123, 22'h3FE123, 1'b0);
        wr(7'd24, 16'hE000, 1'b0);
        wr(7'd26, 16'h001F, 1'b0);
        xl_check("R10 last byte of memory", 18'h0DFFF, 22'h1FFFFF, 1'b1);
        wr(7'd24, 16'h0000, 1'b0);
        wr(7'd26, 16'h0020, 1'b0);
        xl_check("R10 first byte past memory", 18'h0C000, 22'h200000, 1'b0);
    endtask

    // R9: pass-through when disabled.
    task automatic t_passthru;
        @(negedge clk);
        map_enable = 1'b0;
        xl_check("R9 passthru", 18'h2ABCD, 22'h02ABCD, 1'b1);
        xl_check("R9 passthru top page", 18'h3FFFF, 22'h03FFFF, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word();
        t_index();
        t_byte();
        t_absent();
        t_mapped();
        t_passthru();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule